// File: doc/BRIEF.md
# Serial Memory Page Program Engine

This block collects the data bytes of a serial memory write command into a one-page staging buffer. When the command ends cleanly it copies the staged bytes into the memory array and then runs a self-timed programming interval. A command engine tells it when a write command has been decoded. The engine also supplies the start address, one strobe per received data byte, and the chip-select release event with a flag saying whether that release came right after a complete byte. A protection unit supplies a permit level for the target page, and the write-enable latch state is an input.

While the buffer is loading, the byte column, which is the low `COL_W` bits of the address, advances after every byte. The page part of the address never changes, so a long burst wraps inside its own page and later bytes overwrite earlier ones. On a valid commit the block scans all page columns in ascending order. It drives the array write port only for the columns that actually received a byte. It then holds `busy` high for the programming interval, given in system clock cycles. At the end it pulses a request that clears the write-enable latch. A release at the wrong moment, a missing enable, or a refused permit drops the whole command, and no busy interval follows.

Top module: `page_prog_engine`

## Requirements
- R1: A write command (`wr_start` high) is accepted only when `wel` is 1 in the same cycle. Otherwise it is ignored: the following bytes and chip-select release write nothing, and `busy` stays 0.
- R2: The byte column starts at `start_addr[COL_W-1:0]` (bits 4:0 with 32-byte pages) and advances by one, modulo `PAGE_BYTES`, after each `byte_stb`. Every array write of one command carries the page bits `start_addr[ADDR_W-1:COL_W]` unchanged.
- R3: When more than `PAGE_BYTES` bytes arrive, the column wraps and the last byte received for a column is the one written.
- R4: A commit happens only on `cs_rise` with `cs_aligned`=1 after at least one byte. A release with `cs_aligned`=0, or a release with no bytes received, abandons the command: no array write, and `busy` stays 0.
- R5: On commit, only the columns that received a byte are written, each exactly once, in ascending column order. Array writes occur only while `busy` is 1.
- R6: `busy` rises in the cycle after the committing `cs_rise` is sampled and stays high for exactly `PAGE_BYTES + WRITE_CYCLES` cycles.
- R7: `wel_clr` is a single-cycle pulse in the first cycle in which `busy` is low again after a programming interval, and it occurs at no other time.
- R8: If `permit` is 0 when the committing `cs_rise` is sampled, the whole page is dropped: no array write, and `busy` stays 0.
- R9: While `busy` is 1, `wr_start`, `byte_stb` and `cs_rise` have no effect.
- R10: After reset, `busy`, `arr_we` and `wel_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Write command decoded, address valid |
| start_addr | input | ADDR_W | Start byte address of the write |
| wel | input | 1 | Write-enable latch state |
| byte_stb | input | 1 | One received data byte is valid |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip-select release event |
| cs_aligned | input | 1 | Release came right after a complete byte |
| permit | input | 1 | Protection unit allows writing the target page |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit and programming interval in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
A stale or wrongly advanced column pointer shows on the array port during the next commit: bytes land at shifted or out-of-page addresses within the `PAGE_BYTES` scan cycles after the release. A received-byte mask that is not cleared or not set shows as extra or missing array writes in that same scan. A state machine that lingers or skips a state shows as a `busy` interval whose length differs from `PAGE_BYTES + WRITE_CYCLES`, as a misplaced `wel_clr` pulse, or as a busy interval after an abandoned command, all visible within one interval.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_WAIT  = 2'd3
  } ppe_state_e;
endpackage

// File: rtl/ppe_page_buf.sv
module ppe_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_mask,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mark,
  output logic              any_mark
);
  // staging storage, no reset so it maps onto block RAM
  logic [DATA_W-1:0]     mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_col] <= wr_data;
    rd_data <= mem[rd_col];
  end

  // one bit per column: set when that column received a byte
  always_ff @(posedge clk) begin
    if (rst || clr_mask) begin
      mask <= '0;
    end else if (wr_en) begin
      mask[wr_col] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_mark <= 1'b0;
    else     rd_mark <= rd_en & mask[rd_col];
  end

  assign any_mark = |mask;
endmodule

// File: rtl/ppe_timer.sv
module ppe_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (cnt == LAST) running <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign expire = running && (cnt == LAST);
endmodule

// File: rtl/ppe_seq.sv
module ppe_seq
  import ppe_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wel,
  input  logic              byte_stb,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              permit,
  input  logic              any_mark,
  input  logic              timer_expire,
  output logic              clr_mask,
  output logic              buf_wr_en,
  output logic [COL_W-1:0]  buf_wr_col,
  output logic              rd_en,
  output logic [COL_W-1:0]  rd_col,
  output logic              timer_start,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              busy,
  output logic              wel_clr
);
  localparam int PAGE_W = ADDR_W - COL_W;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  ppe_state_e        state;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [COL_W-1:0]  idx;

  logic accept, commit, load_byte, drain_end;

  assign accept    = (state == ST_IDLE) && wr_start && wel;
  assign load_byte = (state == ST_LOAD) && byte_stb && !cs_rise;
  assign commit    = (state == ST_LOAD) && cs_rise && cs_aligned && any_mark && permit;
  assign drain_end = (state == ST_DRAIN) && (idx == LAST_COL);

  assign clr_mask    = accept;
  assign buf_wr_en   = load_byte;
  assign buf_wr_col  = col;
  assign rd_en       = (state == ST_DRAIN);
  assign rd_col      = idx;
  assign timer_start = drain_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      page    <= '0;
      col     <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_LOAD;
            page  <= start_addr[ADDR_W-1:COL_W];
            col   <= start_addr[COL_W-1:0];
          end
        end
        ST_LOAD: begin
          if (cs_rise) begin
            if (commit) begin
              state <= ST_DRAIN;
              idx   <= '0;
              busy  <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else if (load_byte) begin
            col <= col + 1'b1;
          end
        end
        ST_DRAIN: begin
          idx <= idx + 1'b1;
          if (drain_end) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (timer_expire) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            wel_clr <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // address register aligned with the buffer's registered read
  always_ff @(posedge clk) begin
    if (rst) arr_addr <= '0;
    else if (state == ST_DRAIN) arr_addr <= {page, idx};
  end
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wel,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              permit,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              wel_clr
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic             clr_mask, buf_wr_en, rd_en, any_mark;
  logic             timer_start, timer_expire;
  logic [COL_W-1:0] buf_wr_col, rd_col;

  ppe_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .wr_start(wr_start), .start_addr(start_addr), .wel(wel),
    .byte_stb(byte_stb), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
    .permit(permit), .any_mark(any_mark), .timer_expire(timer_expire),
    .clr_mask(clr_mask), .buf_wr_en(buf_wr_en), .buf_wr_col(buf_wr_col),
    .rd_en(rd_en), .rd_col(rd_col), .timer_start(timer_start),
    .arr_addr(arr_addr), .busy(busy), .wel_clr(wel_clr)
  );

  ppe_page_buf #(
    .DATA_W(8), .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)
  ) u_buf (
    .clk(clk), .rst(rst), .clr_mask(clr_mask),
    .wr_en(buf_wr_en), .wr_col(buf_wr_col), .wr_data(byte_data),
    .rd_en(rd_en), .rd_col(rd_col),
    .rd_data(arr_wdata), .rd_mark(arr_we), .any_mark(any_mark)
  );

  ppe_timer #(
    .CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk(clk), .rst(rst), .start(timer_start), .expire(timer_expire)
  );
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 250000
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_rise,
  input logic              cs_aligned,
  input logic              permit,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic              wel_clr
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int TOTAL = PAGE_BYTES + WRITE_CYCLES;

  int unsigned busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:COL_W] == $past(arr_addr[ADDR_W-1:COL_W]))); // R2

  AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && cs_rise && !cs_aligned) |=> !busy); // R4

  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R5

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == TOTAL)); // R6

  AST_WEL_CLR_AT_END: assert property (@(posedge clk) disable iff (rst)
    wel_clr |-> (!busy && $past(busy))); // R7

  AST_WEL_CLR_ONCE: assert property (@(posedge clk) disable iff (rst)
    wel_clr |=> !wel_clr); // R7

  AST_DENIED_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && cs_rise && !permit) |=> !busy); // R8
endmodule

bind page_prog_engine ppe_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
  .permit(permit), .arr_we(arr_we), .arr_addr(arr_addr),
  .busy(busy), .wel_clr(wel_clr)
);

// File: tb/page_prog_engine_test.sv
module page_prog_engine_test;
  localparam int PERIOD = 10;
  localparam int AW     = 12;
  localparam int PB     = 32;
  localparam int WC     = 20;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_start = 0, wel = 0, byte_stb = 0;
  logic          cs_rise = 0, cs_aligned = 0, permit = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    byte_data = '0;
  logic          arr_we, busy, wel_clr;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;

  int vectors = 0;
  int errors  = 0;
  int nwr     = 0;
  bit done    = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] expm  [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  page_prog_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .start_addr(start_addr),
    .wel(wel), .byte_stb(byte_stb), .byte_data(byte_data),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .permit(permit),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .busy(busy), .wel_clr(wel_clr)
  );

  // array model, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      model[arr_addr] = arr_wdata;
      nwr = nwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd_start(input logic [AW-1:0] a, input bit w);
    @(negedge clk); wr_start = 1; start_addr = a; wel = w;
    @(negedge clk); wr_start = 0; wel = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); byte_stb = 1; byte_data = d;
    @(negedge clk); byte_stb = 0;
  endtask

  task automatic release_cs(input bit al, input bit pm);
    @(negedge clk); cs_rise = 1; cs_aligned = al; permit = pm;
    @(negedge clk); cs_rise = 0; cs_aligned = 0; permit = 0;
  endtask

  // called right after release_cs of a valid commit
  task automatic expect_commit(input string req);
    int n = 0;
    chk(busy == 1'b1, "R6 busy rises", busy, 1);
    while (busy && n < 10000) begin n++; @(negedge clk); end
    chk(n == PB + WC, "R6 busy length", n, PB + WC);
    chk(wel_clr == 1'b1, "R7 wel_clr at busy fall", wel_clr, 1);
    @(negedge clk);
    chk(wel_clr == 1'b0, "R7 wel_clr single pulse", wel_clr, 0);
    chk(1'b1, req, 0, 0);
  endtask

  task automatic expect_idle(input string req, input int nwr_before);
    int bad = 0;
    for (int i = 0; i < PB + WC + 8; i++) begin
      @(negedge clk);
      if (busy || wel_clr) bad++;
    end
    chk(bad == 0, req, bad, 0);
    chk(nwr == nwr_before, req, nwr, nwr_before);
  endtask

  task automatic cmp_page(input logic [AW-1:0] base, input string req);
    int bad = 0;
    for (int i = 0; i < PB; i++) begin
      if (model[base + AW'(i)] !== expm[base + AW'(i)]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0 && arr_we == 0 && wel_clr == 0, "R10 reset outputs",
        {busy, arr_we, wel_clr}, 0);
  endtask

  task automatic t_basic;
    int n0 = nwr;
    cmd_start(12'h123, 1);
    for (int i = 0; i < 4; i++) begin
      push(8'hA0 + 8'(i));
      expm[12'h123 + AW'(i)] = 8'hA0 + 8'(i);
    end
    release_cs(1, 1);
    expect_commit("R5 basic commit");
    chk(nwr - n0 == 4, "R5 only received columns written", nwr - n0, 4);
    cmp_page(12'h120, "R5 page contents basic");
  endtask

  task automatic t_wrap;
    int n0 = nwr;
    cmd_start(12'h05E, 1);
    for (int i = 0; i < 5; i++) begin
      push(8'h30 + 8'(i));
      expm[{7'h02, 5'((30 + i) % 32)}] = 8'h30 + 8'(i);
    end
    release_cs(1, 1);
    expect_commit("R2 wrap commit");
    chk(nwr - n0 == 5, "R2 wrap write count", nwr - n0, 5);
    cmp_page(12'h040, "R2 wrap stays in page");
    chk(model[12'h060] == 8'hEE, "R2 next page untouched", model[12'h060], 8'hEE);
  endtask

  task automatic t_overflow;
    int n0 = nwr;
    cmd_start(12'h200, 1);
    for (int i = 0; i < 34; i++) begin
      push(8'h10 + 8'(i));
      expm[12'h200 + AW'(i % 32)] = 8'h10 + 8'(i);
    end
    release_cs(1, 1);
    expect_commit("R3 overflow commit");
    chk(nwr - n0 == 32, "R3 each column once", nwr - n0, 32);
    chk(model[12'h200] == 8'h30, "R3 last byte wins col0", model[12'h200], 8'h30);
    cmp_page(12'h200, "R3 page contents");
  endtask

  task automatic t_no_wel;
    int n0 = nwr;
    cmd_start(12'h400, 0);
    push(8'h55);
    release_cs(1, 1);
    expect_idle("R1 no enable ignored", n0);
  endtask

  task automatic t_abort;
    int n0 = nwr;
    cmd_start(12'h500, 1);
    push(8'h66);
    release_cs(0, 1);
    expect_idle("R4 misaligned release aborts", n0);
    cmd_start(12'h520, 1);
    release_cs(1, 1);
    expect_idle("R4 zero bytes aborts", n0);
  endtask

  task automatic t_denied;
    int n0 = nwr;
    cmd_start(12'h600, 1);
    push(8'h77);
    push(8'h78);
    release_cs(1, 0);
    expect_idle("R8 denied page dropped", n0);
  endtask

  task automatic t_busy_ignore;
    int n0 = nwr;
    int n = 0;
    cmd_start(12'h300, 1);
    push(8'hC1); expm[12'h300] = 8'hC1;
    push(8'hC2); expm[12'h301] = 8'hC2;
    release_cs(1, 1);
    chk(busy == 1'b1, "R9 busy before ignored cmd", busy, 1);
    cmd_start(12'h310, 1);
    push(8'hAA);
    release_cs(1, 1);
    while (busy && n < 10000) begin n++; @(negedge clk); end
    expect_idle("R9 cmd during busy ignored", n0 + 2);
    cmp_page(12'h300, "R9 page contents");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'hEE;
      expm[i]  = 8'hEE;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_basic();
    t_wrap();
    t_overflow();
    t_no_wel();
    t_abort();
    t_denied();
    t_busy_ignore();
    t_basic_after();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  // a full commit after the abandoned commands still works
  task automatic t_basic_after;
    int n0 = nwr;
    cmd_start(12'hFFF, 1);
    push(8'h9D); expm[12'hFFF] = 8'h9D;
    push(8'h9E); expm[12'hFE0] = 8'h9E;
    release_cs(1, 1);
    expect_commit("R2 top page wrap");
    chk(nwr - n0 == 2, "R5 count after aborts", nwr - n0, 2);
    cmp_page(12'hFE0, "R2 top page contents");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule